// File: doc/BRIEF.md
# Two-Player Score Keeper

This block holds the running score of both players in a two-paddle ball game and decides when a match is over. Each score is kept in two parts: a units digit that counts from 0 to 9, and a single tens bit. When the ball leaves the playfield to the left or right, a miss level rises. On the rising edge of that level, the player on the far side gets one point. No point is given in attract mode, and none is given once the match has ended.

A selector input picks a short match, which ends at 11, or a long match, which ends at 15. The end is found by matching the score against that fixed pattern. The video logic drives a two-bit digit selector from the horizontal beam position. The block answers with a 4-bit code for a shared BCD-to-seven-segment decoder. A tens digit that is clear is sent as code 15, which the decoder shows as blank, so no leading zero appears on screen.

Top module: `rally_score_top`

## Requirements
- R1: Each player's units digit starts at 0 after reset and increments by one for each point. It takes only values 0 to 9, and it changes on the clock edge where the point is taken.
- R2: A point taken while the units digit is 9 sets the units digit to 0 and inverts that player's tens bit on the same edge.
- R3: A point is taken only on a clock edge where `ball_out_i` is high, it was low on the previous edge, and `attract_i` is low. While `attract_i` is high, no score changes.
- R4: If `ball_left_i` is 1 at the point, player two's score increments. If it is 0, player one's score increments.
- R5: `match_over_o` is high exactly when either player's tens bit is 1 and that player's units digit is 1 (with `long_match_i` = 0) or 5 (with `long_match_i` = 1).
- R6: A tens digit is presented as code 1 when the tens bit is set and as code 15 when it is clear. A units digit is presented as its own value.
- R7: A high `clear_scores_i` at a clock edge sets both units digits and both tens bits to zero. It takes priority over a point on the same edge.
- R8: `digit_sel_i` selects the digit code combinationally: 0 selects player one tens, 1 selects player one units, 2 selects player two tens, and 3 selects player two units.
- R9: A miss level that stays high for several cycles adds exactly one point.
- R10: While `match_over_o` is high, rising edges of `ball_out_i` leave both scores unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_scores_i | input | 1 | Clears both scores |
| attract_i | input | 1 | Attract mode; blocks scoring |
| ball_out_i | input | 1 | High while the ball is outside the playfield horizontally |
| ball_left_i | input | 1 | Ball direction: 1 = moving left |
| long_match_i | input | 1 | 0 = match to 11, 1 = match to 15 |
| digit_sel_i | input | 2 | Digit selector from the beam position |
| p1_units_o | output | 4 | Player one units digit |
| p1_tens_o | output | 1 | Player one tens bit |
| p2_units_o | output | 4 | Player two units digit |
| p2_tens_o | output | 1 | Player two tens bit |
| match_over_o | output | 1 | Match ended |
| digit_code_o | output | 4 | Code for the seven-segment decoder |

## Verification
The hardest situation to reach is a score that sits at its limit with the match flag high while further misses arrive. Getting there takes eleven or fifteen distinct rising edges of the miss level, and each edge must have its own low phase. The bench builds that count from many short miss pulses, then sends more pulses after the flag rises and checks that the scores do not move. It then toggles the match-length selector to show that the flag follows the pattern combinationally. The wrap from 9 to 10 and a clear that lands on the same edge as a miss are reached in the same way, by stepping the score one point at a time.

// File: rtl/rally_pkg.sv
package rally_pkg;
  localparam int DIGIT_W    = 4;
  localparam int UNITS_LAST = 9;
  localparam int SHORT_END  = 1;   // units digit at 11
  localparam int LONG_END   = 5;   // units digit at 15
  localparam logic [DIGIT_W-1:0] CODE_ONE   = 4'd1;
  localparam logic [DIGIT_W-1:0] CODE_BLANK = 4'd15;

  function automatic logic [DIGIT_W-1:0] units_step(input logic [DIGIT_W-1:0] u);
    return (u >= DIGIT_W'(UNITS_LAST)) ? '0 : u + 1'b1;
  endfunction

  function automatic logic units_wraps(input logic [DIGIT_W-1:0] u);
    return u == DIGIT_W'(UNITS_LAST);
  endfunction

  function automatic logic [DIGIT_W-1:0] tens_code(input logic t);
    return t ? CODE_ONE : CODE_BLANK;
  endfunction

  function automatic logic at_limit(input logic [DIGIT_W-1:0] u, input logic t,
                                    input logic long_m);
    return t && (u == (long_m ? DIGIT_W'(LONG_END) : DIGIT_W'(SHORT_END)));
  endfunction
endpackage

// File: rtl/rally_miss_edge.sv
module rally_miss_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ball_out_i,
  input  logic attract_i,
  input  logic hold_i,
  output logic point_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ball_out_i;
  end

  assign point_o = ball_out_i && !prev_q && !attract_i && !hold_i;

  // one point per miss level, however long it lasts
  assert_single_point_R9: assert property (@(posedge clk) disable iff (!rst_n)
    point_o |=> !point_o);
endmodule

// File: rtl/rally_player_tally.sv
module rally_player_tally
  import rally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               bump_i,
  output logic [DIGIT_W-1:0] units_o,
  output logic               tens_o
);
  logic [DIGIT_W-1:0] units_q;
  logic               tens_q;
  logic               wrap_w;

  assign wrap_w = bump_i && units_wraps(units_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= '0;
      tens_q  <= 1'b0;
    end else if (clear_i) begin
      units_q <= '0;
      tens_q  <= 1'b0;
    end else if (bump_i) begin
      units_q <= units_step(units_q);
      if (wrap_w) tens_q <= ~tens_q;
    end
  end

  assign units_o = units_q;
  assign tens_o  = tens_q;

  assert_units_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    units_q <= DIGIT_W'(UNITS_LAST));
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump_i && !clear_i) |=> ($stable(units_q) && $stable(tens_q)));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_i && !clear_i && units_q == DIGIT_W'(UNITS_LAST)) |=>
      (units_q == '0 && tens_q != $past(tens_q)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (units_q == '0 && !tens_q));
endmodule

// File: rtl/rally_digit_mux.sv
module rally_digit_mux
  import rally_pkg::*;
(
  input  logic [1:0]         sel_i,
  input  logic [DIGIT_W-1:0] p1_units_i,
  input  logic               p1_tens_i,
  input  logic [DIGIT_W-1:0] p2_units_i,
  input  logic               p2_tens_i,
  output logic [DIGIT_W-1:0] code_o
);
  always_comb begin
    unique case (sel_i)
      2'd0: code_o = tens_code(p1_tens_i);
      2'd1: code_o = p1_units_i;
      2'd2: code_o = tens_code(p2_tens_i);
      default: code_o = p2_units_i;
    endcase
  end

  always_comb begin
    if (sel_i == 2'd0 && !p1_tens_i)
      assert_blank_lead_R6: assert (code_o == CODE_BLANK);
  end
endmodule

// File: rtl/rally_score_top.sv
module rally_score_top
  import rally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_scores_i,
  input  logic               attract_i,
  input  logic               ball_out_i,
  input  logic               ball_left_i,
  input  logic               long_match_i,
  input  logic [1:0]         digit_sel_i,
  output logic [DIGIT_W-1:0] p1_units_o,
  output logic               p1_tens_o,
  output logic [DIGIT_W-1:0] p2_units_o,
  output logic               p2_tens_o,
  output logic               match_over_o,
  output logic [DIGIT_W-1:0] digit_code_o
);
  localparam int PLAYERS = 2;

  logic                 point_w;
  logic [PLAYERS-1:0]   bump_w;
  logic [DIGIT_W-1:0]   units_w [PLAYERS];
  logic [PLAYERS-1:0]   tens_w;

  rally_miss_edge edge_i (
    .clk(clk), .rst_n(rst_n), .ball_out_i(ball_out_i),
    .attract_i(attract_i), .hold_i(match_over_o), .point_o(point_w)
  );

  // index 0 = player one (ball moving right), 1 = player two (ball moving left)
  assign bump_w[0] = point_w && !ball_left_i;
  assign bump_w[1] = point_w &&  ball_left_i;

  for (genvar p = 0; p < PLAYERS; p++) begin : g_player
    rally_player_tally tally_i (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_scores_i),
      .bump_i(bump_w[p]), .units_o(units_w[p]), .tens_o(tens_w[p])
    );
  end

  assign p1_units_o   = units_w[0];
  assign p1_tens_o    = tens_w[0];
  assign p2_units_o   = units_w[1];
  assign p2_tens_o    = tens_w[1];
  assign match_over_o = at_limit(units_w[0], tens_w[0], long_match_i) ||
                        at_limit(units_w[1], tens_w[1], long_match_i);

  rally_digit_mux mux_i (
    .sel_i(digit_sel_i), .p1_units_i(units_w[0]), .p1_tens_i(tens_w[0]),
    .p2_units_i(units_w[1]), .p2_tens_i(tens_w[1]), .code_o(digit_code_o)
  );

  assert_attract_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    attract_i |-> (bump_w == '0));
  assert_route_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bump_w[1] |-> ball_left_i);
  assert_route_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bump_w[0] |-> !ball_left_i);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_over_o && !clear_scores_i) |=> ($stable(p1_units_o) && $stable(p2_units_o)
                                           && $stable(p1_tens_o) && $stable(p2_tens_o)));
endmodule

// File: tb/rally_score_top_tb_top.sv
module rally_score_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_scores_i = 0, attract_i = 0, ball_out_i = 0, ball_left_i = 0;
  logic long_match_i = 0;
  logic [1:0] digit_sel_i = 0;
  logic [3:0] p1_units_o, p2_units_o, digit_code_o;
  logic p1_tens_o, p2_tens_o, match_over_o;

  int checks = 0, fails = 0;
  int s1 = 0, s2 = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rally_score_top dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit over_m();
    int lim = long_match_i ? 15 : 11;
    return (s1 == lim) || (s2 == lim);
  endfunction

  task automatic check_scores(input string req);
    check({req, " p1 units"}, p1_units_o, s1 % 10);
    check({req, " p1 tens"},  p1_tens_o, (s1 / 10) % 2);
    check({req, " p2 units"}, p2_units_o, s2 % 10);
    check({req, " p2 tens"},  p2_tens_o, (s2 / 10) % 2);
    check({req, " over"},     match_over_o, over_m());
  endtask

  // raise the miss level for len cycles, update the model
  task automatic miss(input bit left, input int len);
    bit take = !attract_i && !over_m();
    @(negedge clk);
    ball_left_i = left;
    ball_out_i  = 1'b1;
    repeat (len) @(negedge clk);
    ball_out_i = 1'b0;
    @(negedge clk);
    if (take) begin
      if (left) s2++; else s1++;
    end
  endtask

  task automatic check_digits(input string req);
    for (int k = 0; k < 4; k++) begin
      int exp;
      digit_sel_i = k[1:0];
      #1;
      case (k)
        0: exp = ((s1 / 10) % 2) ? 1 : 15;
        1: exp = s1 % 10;
        2: exp = ((s2 / 10) % 2) ? 1 : 15;
        default: exp = s2 % 10;
      endcase
      check({req, " digit code"}, digit_code_o, exp);
    end
  endtask

  task automatic t_reset();
    check_scores("R1 reset");
    check_digits("R6 R8 reset");
  endtask

  task automatic t_direction();
    miss(1'b0, 1); check_scores("R4 right miss");
    miss(1'b1, 1); check_scores("R4 left miss");
  endtask

  task automatic t_long_pulse();
    miss(1'b0, 6); check_scores("R9 long pulse");
  endtask

  task automatic t_attract();
    attract_i = 1'b1;
    miss(1'b1, 1); miss(1'b0, 2);
    check_scores("R3 attract");
    attract_i = 1'b0;
  endtask

  task automatic t_clear_priority();
    @(negedge clk);
    clear_scores_i = 1'b1; ball_out_i = 1'b1; ball_left_i = 1'b0;
    @(negedge clk);
    clear_scores_i = 1'b0; ball_out_i = 1'b0;
    @(negedge clk);
    s1 = 0; s2 = 0;
    check_scores("R7 clear with miss");
  endtask

  task automatic t_wrap();
    repeat (9) miss(1'b0, 1);
    check_scores("R1 at nine");
    check_digits("R6 nine");
    miss(1'b0, 1);
    check_scores("R2 wrap to ten");
    check_digits("R6 R8 ten");
  endtask

  task automatic t_short_end();
    miss(1'b0, 1);
    check_scores("R5 eleven short");
    miss(1'b0, 1); miss(1'b1, 1);
    check_scores("R10 frozen");
    @(negedge clk); long_match_i = 1'b1; #1;
    check("R5 long sel at eleven", match_over_o, 0);
    @(negedge clk); long_match_i = 1'b0; #1;
    check("R5 short sel again", match_over_o, 1);
  endtask

  task automatic t_long_end();
    @(negedge clk); clear_scores_i = 1'b1; long_match_i = 1'b1;
    @(negedge clk); clear_scores_i = 1'b0; s1 = 0; s2 = 0;
    repeat (14) miss(1'b1, 1);
    check_scores("R5 fourteen long");
    miss(1'b1, 1);
    check_scores("R5 fifteen long");
    check_digits("R8 fifteen");
    miss(1'b0, 1);
    check_scores("R10 frozen long");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_long_pulse();
    t_attract();
    t_clear_priority();
    t_wrap();
    t_short_end();
    t_long_end();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule